// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block moves a device transfer between a 16-bit device-side stream and system memory. The memory side is described by a table of descriptors. Software programs three registers: a table pointer, a status word and a command word. It also presents the device transfer length in bytes. It then sets the start bit. The engine reads each 8-byte descriptor over a 32-bit memory port, and then moves halfwords to or from the buffer that the descriptor names. It counts bytes against both the descriptor and the device length.

When the engine stops, the status word tells software how the table compared with the device transfer. The table can be short (an error), exactly right, or larger than the transfer. Clearing the start bit stops the engine at any point.

The device streams use valid/ready. A source must hold `s_valid` and `s_data` until `s_ready`. The engine holds `m_valid` and `m_data` until `m_ready`, except when software aborts the transfer. Back-pressure on either stream, or a slow `mem_ack`, only stretches the transfer in time.

Top module: `sg_desc_dma`

## Requirements
- R1: A descriptor is two 32-bit words at the walk pointer. The first word is the buffer byte address. The second word holds the byte count in bits 15:0 and the last-descriptor flag in bit 31. The walk starts at the table pointer and advances by 8 bytes per descriptor. Buffers are filled or drained in descriptor order, one halfword per stream beat.
- R2: Bit 0 of a descriptor byte count is ignored. A count field of 0 stands for 65536 bytes.
- R3: The command word has start in bit 0 and direction in bit 3, where 1 means device to memory. Active (status bit 0) sets on the clock edge that writes start from 0 to 1. Direction can be changed only while start is 0.
- R4: When the descriptors cover exactly the device length, ending on a last-flagged descriptor, the engine ends with interrupt (status bit 2) set and active clear.
- R5: When a last-flagged descriptor is used up before the device length, the engine ends with interrupt clear, active clear and error (status bit 1) set.
- R6: When the device length is used up while descriptor bytes remain, or the exhausted descriptor is not flagged last, the engine ends with interrupt and active both set. Active stays set until start is cleared.
- R7: Writing start to 0 stops the engine and clears active at that edge. The interrupt and error bits keep their values, so an aborted short or unfinished transfer shows 0 for both and an aborted oversized one shows interrupt only.
- R8: Writing 1 to status bit 2 or bit 1 clears that bit. A completion that sets a bit in the same cycle wins over the clear.
- R9: The table pointer reads back with bits 1:0 forced to zero.
- R10: Memory accesses are word-aligned. A write carries one halfword in the lane chosen by address bit 1, with byte enables 0011 or 1100. A request and its address stay stable until `mem_ack`. Read data is taken in the ack cycle.
- R11: `m_valid` with `m_data` is held until `m_ready`. `s_ready` rises only in the cycle in which the memory write that carries `s_data` is acknowledged.
- R12: `irq` follows status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 command, 1 status, 2 table pointer |
| reg_wr_data | input | 32 | Register write data |
| cmd_o | output | 8 | Command word readback |
| stat_o | output | 8 | Status word: bit 0 active, 1 error, 2 interrupt |
| tbl_ptr_o | output | ADDR_W | Table pointer readback |
| irq | output | 1 | Interrupt line |
| dev_len | input | LEN_W | Device transfer length in bytes, sampled at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, valid with ack |
| s_valid | input | 1 | Device-to-memory stream valid |
| s_ready | output | 1 | Device-to-memory stream ready |
| s_data | input | 16 | Device-to-memory halfword |
| m_valid | output | 1 | Memory-to-device stream valid |
| m_ready | input | 1 | Memory-to-device stream ready |
| m_data | output | 16 | Memory-to-device halfword |

## Verification
A completion event that sets the interrupt bit can fall in the same cycle as a software write that clears that bit. The bench provokes this by repeating the clear write on every cycle while the interrupt reads 0, so the last write always lands on the completing edge. The interrupt must then read 1, because the set has priority.

An abort can also meet a stalled stream beat. Here the bench holds `m_ready` low and checks that `m_valid` drops together with active.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_TBL  = 2'd2;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_DIR_BIT  = 3;
  localparam int ST_ACT_BIT   = 0;
  localparam int ST_ERR_BIT   = 1;
  localparam int ST_IRQ_BIT   = 2;
  localparam int DESC_LAST_BIT = 31;
  localparam int CNT_W        = 16;

  typedef enum logic [2:0] {
    W_IDLE, W_ADDR, W_CTRL, W_MOVE, W_PUSH
  } walk_state_e;

  typedef struct packed {
    logic set_irq;
    logic keep_act;
    logic set_err;
  } finish_t;
endpackage

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fin_valid,
  input  finish_t           fin,
  output logic              go,
  output logic              stop,
  output logic              dir,
  output logic [ADDR_W-1:0] tbl_base,
  output logic [7:0]        cmd_o,
  output logic [7:0]        stat_o
);
  logic start_q, dir_q, act_q, err_q, irq_q;
  logic [ADDR_W-3:0] tbl_q;
  logic cmd_wr, stat_wr;

  assign cmd_wr  = wr_en && (wr_sel == SEL_CMD);
  assign stat_wr = wr_en && (wr_sel == SEL_STAT);
  assign go      = cmd_wr && wr_data[CMD_GO_BIT] && !start_q;
  assign stop    = cmd_wr && !wr_data[CMD_GO_BIT] && start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      tbl_q   <= '0;
    end else begin
      if (cmd_wr) begin
        start_q <= wr_data[CMD_GO_BIT];
        if (!start_q) dir_q <= wr_data[CMD_DIR_BIT];
      end
      if (wr_en && (wr_sel == SEL_TBL)) tbl_q <= wr_data[ADDR_W-1:2];
      if (go)             act_q <= 1'b1;
      else if (stop)      act_q <= 1'b0;
      else if (fin_valid) act_q <= fin.keep_act;
      irq_q <= (irq_q && !(stat_wr && wr_data[ST_IRQ_BIT])) || (fin_valid && fin.set_irq);
      err_q <= (err_q && !(stat_wr && wr_data[ST_ERR_BIT])) || (fin_valid && fin.set_err);
    end
  end

  assign dir      = dir_q;
  assign tbl_base = {tbl_q, 2'b00};
  assign cmd_o    = {4'b0000, dir_q, 2'b00, start_q};
  assign stat_o   = {5'b00000, irq_q, err_q, act_q};
endmodule

// File: rtl/sg_dma_tally.sv
module sg_dma_tally
  import sg_dma_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_dev,
  input  logic [LEN_W-1:0] dev_len,
  input  logic             load_desc,
  input  logic [CNT_W-1:0] desc_cnt,
  input  logic             step,
  output logic             dev_zero,
  output logic             desc_zero
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL_SPAN = REM_W'(1) << CNT_W;

  logic [LEN_W-1:0] dev_rem_q;
  logic [REM_W-1:0] desc_rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_rem_q  <= '0;
      desc_rem_q <= '0;
    end else begin
      if (load_dev) dev_rem_q <= dev_len & ~LEN_W'(1);
      else if (step) dev_rem_q <= dev_rem_q - LEN_W'(2);
      if (load_desc)
        desc_rem_q <= (desc_cnt == '0) ? FULL_SPAN : REM_W'(desc_cnt & ~CNT_W'(1));
      else if (step) desc_rem_q <= desc_rem_q - REM_W'(2);
    end
  end

  assign dev_zero  = (dev_rem_q == '0);
  assign desc_zero = (desc_rem_q == '0);
endmodule

// File: rtl/sg_dma_walker.sv
module sg_dma_walker
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              stop,
  input  logic              dir,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              dev_zero,
  input  logic              desc_zero,
  output logic              load_desc,
  output logic [CNT_W-1:0]  desc_cnt,
  output logic              step,
  output logic              fin_valid,
  output finish_t           fin,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W/2-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W/2-1:0] m_data
);
  localparam int HALF_W = DATA_W / 2;

  walk_state_e state_q;
  logic [ADDR_W-1:0] wptr_q, buf_q;
  logic              last_q;
  logic [HALF_W-1:0] hold_q;
  logic              can_move;
  logic [ADDR_W-1:0] buf_word;

  assign can_move = !dev_zero && !desc_zero;
  assign buf_word = {buf_q[ADDR_W-1:2], 2'b00};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'b0000;
    mem_wdata = {s_data, s_data};
    s_ready   = 1'b0;
    m_valid   = 1'b0;
    m_data    = hold_q;
    step      = 1'b0;
    fin_valid = 1'b0;
    fin       = '0;
    load_desc = (state_q == W_CTRL) && mem_ack;
    desc_cnt  = mem_rdata[CNT_W-1:0];
    case (state_q)
      W_ADDR: begin
        mem_req  = 1'b1;
        mem_addr = wptr_q;
      end
      W_CTRL: begin
        mem_req  = 1'b1;
        mem_addr = wptr_q + ADDR_W'(4);
      end
      W_MOVE: begin
        if (can_move) begin
          mem_addr = buf_word;
          if (dir) begin
            mem_req = s_valid;
            mem_we  = 1'b1;
            mem_be  = buf_q[1] ? 4'b1100 : 4'b0011;
            s_ready = mem_ack;
            step    = mem_ack;
          end else begin
            mem_req = 1'b1;
          end
        end else if (dev_zero) begin
          fin_valid    = !stop;
          fin.set_irq  = 1'b1;
          fin.keep_act = !(desc_zero && last_q);
        end else if (last_q) begin
          fin_valid   = !stop;
          fin.set_err = 1'b1;
        end
      end
      W_PUSH: begin
        m_valid = 1'b1;
        step    = m_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      wptr_q  <= '0;
      buf_q   <= '0;
      last_q  <= 1'b0;
      hold_q  <= '0;
    end else if (stop) begin
      state_q <= W_IDLE;
    end else if (go) begin
      state_q <= W_ADDR;
      wptr_q  <= tbl_base;
    end else begin
      case (state_q)
        W_ADDR: if (mem_ack) begin
          buf_q   <= mem_rdata[ADDR_W-1:0] & ~ADDR_W'(1);
          state_q <= W_CTRL;
        end
        W_CTRL: if (mem_ack) begin
          last_q  <= mem_rdata[DESC_LAST_BIT];
          wptr_q  <= wptr_q + ADDR_W'(8);
          state_q <= W_MOVE;
        end
        W_MOVE: begin
          if (can_move) begin
            if (mem_ack) begin
              if (dir) begin
                buf_q <= buf_q + ADDR_W'(2);
              end else begin
                hold_q  <= buf_q[1] ? mem_rdata[DATA_W-1:HALF_W] : mem_rdata[HALF_W-1:0];
                state_q <= W_PUSH;
              end
            end
          end else if (dev_zero || last_q) begin
            state_q <= W_IDLE;
          end else begin
            state_q <= W_ADDR;
          end
        end
        W_PUSH: if (m_ready) begin
          buf_q   <= buf_q + ADDR_W'(2);
          state_q <= W_MOVE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sg_desc_dma.sv
module sg_desc_dma
  import sg_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  output logic [7:0]        cmd_o,
  output logic [7:0]        stat_o,
  output logic [ADDR_W-1:0] tbl_ptr_o,
  output logic              irq,
  input  logic [LEN_W-1:0]  dev_len,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [15:0]       s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [15:0]       m_data
);
  localparam int DATA_W = 32;

  logic go, stop, dir, fin_valid, load_desc, step, dev_zero, desc_zero;
  logic [CNT_W-1:0] desc_cnt;
  finish_t fin;

  sg_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .fin_valid(fin_valid), .fin(fin), .go(go),
    .stop(stop), .dir(dir), .tbl_base(tbl_ptr_o), .cmd_o(cmd_o), .stat_o(stat_o)
  );

  sg_dma_tally #(.LEN_W(LEN_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .load_dev(go), .dev_len(dev_len),
    .load_desc(load_desc), .desc_cnt(desc_cnt), .step(step),
    .dev_zero(dev_zero), .desc_zero(desc_zero)
  );

  sg_dma_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .stop(stop), .dir(dir),
    .tbl_base(tbl_ptr_o), .dev_zero(dev_zero), .desc_zero(desc_zero),
    .load_desc(load_desc), .desc_cnt(desc_cnt), .step(step),
    .fin_valid(fin_valid), .fin(fin), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  assign irq = stat_o[ST_IRQ_BIT];
endmodule

// File: rtl/sg_desc_dma_chk.sv
module sg_desc_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_wr_sel,
  input logic [31:0]       reg_wr_data,
  input logic [7:0]        stat_o,
  input logic [ADDR_W-1:0] tbl_ptr_o,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              mem_ack,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [15:0]       m_data
);
  logic abort_wr, start_wr;
  assign abort_wr = reg_wr_en && (reg_wr_sel == 2'd0) && !reg_wr_data[0];
  assign start_wr = reg_wr_en && (reg_wr_sel == 2'd0) && reg_wr_data[0];

  assert_start_sets_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[0]) |-> $past(start_wr));

  assert_err_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[1]) |-> !stat_o[0]);

  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr && stat_o[0] |=> !stat_o[0]);

  assert_ptr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_ptr_o[1:0] == 2'b00);

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !abort_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_word_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00) && (!mem_we || mem_be == 4'b0011 || mem_be == 4'b1100));

  assert_out_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !abort_wr |=> m_valid && $stable(m_data));

  assert_ready_with_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> mem_req && mem_we && mem_ack);
endmodule

bind sg_desc_dma sg_desc_dma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
  .reg_wr_data(reg_wr_data), .stat_o(stat_o), .tbl_ptr_o(tbl_ptr_o),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_ack(mem_ack), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data)
);

// File: tb/test_sg_desc_dma.sv
module test_sg_desc_dma;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 20;
  localparam logic [31:0] LAST = 32'h8000_0000;

  // vector: dir | len[20] | cnt_a[16] | cnt_b[16] | two | expected status[3]
  localparam int NV = 9;
  localparam logic [56:0] VECS [0:NV-1] = '{
    {1'b1, 20'd64, 16'd64,  16'd0,  1'b0, 3'b100},
    {1'b0, 20'd64, 16'd64,  16'd0,  1'b0, 3'b100},
    {1'b1, 20'd64, 16'd32,  16'd32, 1'b1, 3'b100},
    {1'b1, 20'd64, 16'd32,  16'd0,  1'b0, 3'b010},
    {1'b1, 20'd64, 16'd128, 16'd0,  1'b0, 3'b101},
    {1'b0, 20'd64, 16'd40,  16'd16, 1'b1, 3'b010},
    {1'b0, 20'd32, 16'd16,  16'd32, 1'b1, 3'b101},
    {1'b1, 20'd64, 16'd65,  16'd0,  1'b0, 3'b100},
    {1'b1, 20'd64, 16'd64,  16'd16, 1'b1, 3'b101}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = 32'd0;
  logic [7:0] cmd_o, stat_o;
  logic [31:0] tbl_ptr_o;
  logic irq;
  logic [LEN_W-1:0] dev_len = '0;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic s_valid = 1'b0, s_ready;
  logic [15:0] s_data, m_data;
  logic m_valid, m_ready = 1'b0;

  logic [31:0] mem [0:1023];
  logic ack_en = 1'b0, stall_on = 1'b0, block_out = 1'b0, in_hs_q = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int in_idx = 0, out_idx = 0, data_err = 0, cur_ca = 0;
  int n_cmp = 0, n_bad = 0;

  sg_desc_dma #(.ADDR_W(32), .LEN_W(LEN_W)) i_sg_desc_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .cmd_o(cmd_o), .stat_o(stat_o),
    .tbl_ptr_o(tbl_ptr_o), .irq(irq), .dev_len(dev_len), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = mem[mem_addr[11:2]];
  assign s_data    = in_idx[15:0] ^ 16'h3C00;

  function automatic logic [15:0] pat(input int a);
    return a[15:0] ^ 16'hA5A5;
  endfunction

  function automatic int exp_addr(input int k, input int ca);
    int a1 = ca & 32'hFFFE;
    return (2 * k < a1) ? 32'h100 + 2 * k : 32'h200 + 2 * k - a1;
  endfunction

  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ack_en  <= stall_on ? lfsr[0] : 1'b1;
    m_ready <= block_out ? 1'b0 : (stall_on ? lfsr[3] : 1'b1);
    if (s_valid && !in_hs_q) s_valid <= 1'b1;
    else s_valid <= stall_on ? lfsr[5] : 1'b1;
  end

  always @(posedge clk) begin
    in_hs_q <= s_valid && s_ready;
    if (s_valid && s_ready) in_idx <= in_idx + 1;
    if (m_valid && m_ready) begin
      if (m_data !== pat(exp_addr(out_idx, cur_ca))) data_err <= data_err + 1;
      out_idx <= out_idx + 1;
    end
    if (mem_req && mem_ack && mem_we) begin
      if (mem_be[0]) mem[mem_addr[11:2]][15:0]  <= mem_wdata[15:0];
      if (mem_be[2]) mem[mem_addr[11:2]][31:16] <= mem_wdata[31:16];
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic setup(input bit dir, input int len, input int ca, input int cb, input bit two);
    mem[0] = 32'h100;
    mem[1] = (two ? 32'd0 : LAST) | ca;
    mem[2] = 32'h200;
    mem[3] = LAST | cb;
    for (int w = 64; w < 192; w++) mem[w] = dir ? 32'd0 : {pat(w * 4 + 2), pat(w * 4)};
    in_idx = 0; out_idx = 0; data_err = 0; cur_ca = ca;
    dev_len = LEN_W'(len);
    wr(2'd1, 32'h6);
    wr(2'd2, 32'h0);
  endtask

  task automatic wait_done(input int guard);
    for (int g = 0; g < guard && !(stat_o[2] || stat_o[1]); g++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [56:0] v);
    bit dir = v[56];
    int len = int'(v[55:36]);
    int ca = int'(v[35:20]);
    int cb = int'(v[19:4]);
    bit two = v[3];
    logic [2:0] ex = v[2:0];
    string tag = (ex == 3'b100) ? "R4" : (ex == 3'b010) ? "R5" : "R6";
    int tot = (ca & 32'hFFFE) + (two ? (cb & 32'hFFFE) : 0);
    int beats = ((len < tot) ? len : tot) / 2;
    int bad = 0;
    setup(dir, len, ca, cb, two);
    wr(2'd0, {28'd0, dir, 3'b001});
    wait_done(5000);
    check(tag, "status", stat_o[2:0], ex);
    check("R12", "irq", irq, ex[2]);
    check("R1", "beats", dir ? in_idx : out_idx, beats);
    if (dir) begin
      for (int k = 0; k < beats; k++) begin
        int a = exp_addr(k, ca);
        logic [15:0] h = a[1] ? mem[a[11:2]][31:16] : mem[a[11:2]][15:0];
        if (h !== (k[15:0] ^ 16'h3C00)) bad++;
      end
      check("R10", "memory halfwords", bad, 0);
    end else begin
      check("R11", "stream halfwords", data_err, 0);
    end
    wr(2'd0, {28'd0, dir, 3'b000});
    check("R7", "status after stop", stat_o[2:0], ex & 3'b110);
    wr(2'd1, 32'h6);
    check("R8", "status after clear", stat_o[2:0], 3'b000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "reset status", stat_o, 8'h00);
    check("R3", "reset command", cmd_o, 8'h00);
    check("R12", "reset irq", irq, 1'b0);
    check("R10", "reset mem_req", mem_req, 1'b0);
    check("R11", "reset m_valid", m_valid, 1'b0);

    wr(2'd2, 32'h0000_1237);
    check("R9", "pointer low bits", tbl_ptr_o, 32'h0000_1234);

    for (int pass = 0; pass < 2; pass++) begin
      stall_on = (pass == 1);
      for (int v = 0; v < NV; v++) run_vec(VECS[v]);
    end
    stall_on = 1'b0;

    // R2: a zero count field spans 65536 bytes
    setup(1'b1, 65536, 0, 0, 1'b0);
    wr(2'd0, 32'h9);
    check("R3", "active after start", stat_o[0], 1'b1);
    check("R3", "command readback", cmd_o, 8'h09);
    wait_done(80000);
    check("R2", "full-span status", stat_o[2:0], 3'b100);
    check("R2", "full-span beats", in_idx, 32768);
    wr(2'd0, 32'h8);
    wr(2'd1, 32'h6);

    // R8: clear write lands on the completing edge; the set must win
    setup(1'b1, 16, 16, 0, 1'b0);
    wr(2'd0, 32'h9);
    for (int g = 0; g < 2000 && !stat_o[2]; g++) begin
      reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = 32'h4;
      @(negedge clk);
    end
    reg_wr_en = 1'b0;
    check("R8", "set beats clear", stat_o[2:0], 3'b100);
    wr(2'd0, 32'h8);
    wr(2'd1, 32'h4);
    check("R8", "interrupt cleared", stat_o[2], 1'b0);
    check("R3", "direction held while stopped", cmd_o, 8'h08);

    // R7: abort while a memory-to-device beat is stalled
    block_out = 1'b1;
    setup(1'b0, 64, 64, 0, 1'b0);
    wr(2'd0, 32'h1);
    repeat (10) @(negedge clk);
    check("R7", "running status", stat_o[2:0], 3'b001);
    check("R11", "beat held", m_valid, 1'b1);
    wr(2'd0, 32'h0);
    check("R7", "aborted status", stat_o[2:0], 3'b000);
    check("R7", "beat withdrawn", m_valid, 1'b0);
    check("R7", "no memory request", mem_req, 1'b0);
    block_out = 1'b0;

    finish_run();
  end
endmodule